// File: doc/BRIEF.md
# Address-Masked GPIO Port

The block is a general-purpose I/O port of `N_PINS` pins (eight by default) sitting on a simple single-cycle register bus. Each pin has a direction bit, a data latch and an alternate-function select bit. When a pin is in GPIO mode, its direction bit decides whether the pad driver is enabled. When the pin is enabled as an output, the latch value drives the pad. When the alternate select bit is set, the pin is handed to a peripheral: the pad output and pad output enable come from that peripheral, and the raw pad level is passed back to it.

The data register is not a single address. It is a window of 256 word locations, and the word-address bits `bus_addr[9:2]` act as a per-pin mask for the access. A write changes only the latch bits whose mask bit is 1. A read returns the pin values in the masked positions and zero in all others. Software can therefore set, clear or sample any group of pins in one bus access, with no read-modify-write. Pad inputs go through a synchronizer before they are read.

The direction and alternate-select registers are at fixed word offsets above the data window.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset, the direction register, the alternate-select register and all data latches are 0. As a result, pad_oe and pad_out are all 0 and every pin is a GPIO input.
- R2: For a GPIO pin, pad_oe equals its direction bit (1 = output). While that bit is 1, pad_out carries the latch bit. While it is 0, pad_out is 0.
- R3: A write to the data window at byte address `{2'b00, m[7:0], 2'b00}` loads bus_wdata into the latch only where m has a 1. Every latch bit where m has a 0 keeps its value. This includes m = 0x00, which changes nothing, and m = 0xFF, which loads all eight bits.
- R4: A read in the data window returns, in each bit where the address mask is 1, the value of that pin, and 0 in every other bit.
- R5: The pin value read is the latch bit for a pin whose direction bit is 1. For a pin whose direction bit is 0, it is the pad level delayed by exactly `SYNC_STAGES` rising clock edges (2 by default).
- R6: A data-window write to a GPIO output pin shows on pad_out after the clock edge that accepts the write, and not before it.
- R7: A write to a pin whose direction bit is 0 is stored in the latch without driving the pad. Setting the direction bit later drives the stored value.
- R8: For a pin whose alternate-select bit is 1, pad_out and pad_oe follow alt_out and alt_oe, and alt_in carries pad_in. For a pin whose alternate-select bit is 0, alt_in is 0.
- R9: The direction register is at byte address 0x400 and the alternate-select register is at 0x404. Both are read and written as whole registers. Several accesses write nothing and read 0: other offsets in 0x400–0x7FC, any address at 0x800 or above, and any address with bus_addr[1:0] ≠ 0. bus_rdata is 0 when no read is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [9:2] are the pin mask in the data window |
| bus_wdata | input | N_PINS | Write data |
| bus_rdata | output | N_PINS | Read data, combinational from the address |
| pad_in | input | N_PINS | Level seen at the pads |
| pad_out | output | N_PINS | Value driven to the pads |
| pad_oe | output | N_PINS | Pad driver enable |
| alt_out | input | N_PINS | Peripheral output per pin |
| alt_oe | input | N_PINS | Peripheral output enable per pin |
| alt_in | output | N_PINS | Pad level handed to the peripheral |

## Verification
The bench builds the port with its defaults: eight pins, mask field at bit 2 and a two-stage synchronizer. With these values all 256 mask addresses are reachable by bench arithmetic, and the synchronizer's two-edge delay can be observed one edge at a time. The directed scenarios mix input, output and alternate pins within one access, so that masked-off pins and pins owned by a peripheral are checked in the same cycle as the pins being changed.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Upper two byte-address bits pick the region of the port.
  typedef enum logic [1:0] {
    RGN_DATA  = 2'd0,
    RGN_CTRL  = 2'd1,
    RGN_NONE2 = 2'd2,
    RGN_NONE3 = 2'd3
  } region_e;

  // Word index inside the control region.
  localparam int unsigned CTRL_IDX_DIR = 0;
  localparam int unsigned CTRL_IDX_ALT = 1;

  // Decoded access strobes, at most one set per cycle.
  typedef struct packed {
    logic data_wr;
    logic data_rd;
    logic dir_wr;
    logic dir_rd;
    logic alt_wr;
    logic alt_rd;
  } bus_dec_t;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS   = 8,
  parameter int unsigned MASK_LSB = 2,
  localparam int unsigned ADDR_W  = MASK_LSB + N_PINS + 2
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output bus_dec_t          dec,
  output logic [N_PINS-1:0] mask
);

  region_e            region;
  logic               aligned;
  logic [N_PINS-1:0]  word_idx;

  // Region is taken from the top two address bits.
  function automatic region_e region_of(input logic [ADDR_W-1:0] a);
    return region_e'(a[ADDR_W-1 -: 2]);
  endfunction

  assign region   = region_of(addr);
  assign aligned  = (addr[MASK_LSB-1:0] == '0);
  assign word_idx = addr[MASK_LSB +: N_PINS];
  assign mask     = word_idx;

  always_comb begin
    dec = '0;
    if (sel && aligned) begin
      unique case (region)
        RGN_DATA: begin
          dec.data_wr = wr;
          dec.data_rd = !wr;
        end
        RGN_CTRL: begin
          if (word_idx == N_PINS'(CTRL_IDX_DIR)) begin
            dec.dir_wr = wr;
            dec.dir_rd = !wr;
          end else if (word_idx == N_PINS'(CTRL_IDX_ALT)) begin
            dec.alt_wr = wr;
            dec.alt_rd = !wr;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] din,
  output logic [N_PINS-1:0] dout
);

  logic [N_PINS-1:0] stg [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[SYNC_STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_dec_t          dec,
  input  logic [N_PINS-1:0] mask,
  input  logic [N_PINS-1:0] wdata,
  output logic [N_PINS-1:0] latch_q,
  output logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] alt_q
);

  // Bits under the mask take the new value, the rest keep the old one.
  function automatic logic [N_PINS-1:0] masked_merge(
    input logic [N_PINS-1:0] old_v,
    input logic [N_PINS-1:0] new_v,
    input logic [N_PINS-1:0] m
  );
    return (new_v & m) | (old_v & ~m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      alt_q   <= '0;
    end else begin
      if (dec.data_wr) latch_q <= masked_merge(latch_q, wdata, mask);
      if (dec.dir_wr)  dir_q   <= wdata;
      if (dec.alt_wr)  alt_q   <= wdata;
    end
  end

  AST_MASK_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n) dec.data_wr |=> (((latch_q ^ $past(latch_q)) & ~$past(mask)) == '0)) else $error("masked-off latch bit changed"); // R3
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !dec.data_wr |=> $stable(latch_q)) else $error("latch changed without a data write"); // R3
  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !(dec.dir_wr || dec.alt_wr) |=> ($stable(dir_q) && $stable(alt_q))) else $error("control changed without a control write"); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> (dir_q == '0 && alt_q == '0 && latch_q == '0)) else $error("state not cleared by reset"); // R1

endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux #(
  parameter int unsigned N_PINS = 8
) (
  input  logic [N_PINS-1:0] latch_q,
  input  logic [N_PINS-1:0] dir_q,
  input  logic [N_PINS-1:0] alt_q,
  input  logic [N_PINS-1:0] alt_out,
  input  logic [N_PINS-1:0] alt_oe,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] alt_in
);

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic gpio_out;
    logic gpio_oe;
    assign gpio_oe    = dir_q[i];
    assign gpio_out   = latch_q[i] & dir_q[i];
    assign pad_out[i] = alt_q[i] ? alt_out[i] : gpio_out;
    assign pad_oe[i]  = alt_q[i] ? alt_oe[i]  : gpio_oe;
    assign alt_in[i]  = alt_q[i] & pad_in[i];
  end

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned MASK_LSB    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = MASK_LSB + N_PINS + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  input  logic [N_PINS-1:0] alt_out,
  input  logic [N_PINS-1:0] alt_oe,
  output logic [N_PINS-1:0] alt_in
);

  bus_dec_t          dec;
  logic [N_PINS-1:0] acc_mask;
  logic [N_PINS-1:0] latch_q, dir_q, alt_q;
  logic [N_PINS-1:0] pad_sync;
  logic [N_PINS-1:0] pin_view;

  // Output pins show their latch, input pins their synchronized pad.
  function automatic logic [N_PINS-1:0] pin_value(
    input logic [N_PINS-1:0] dir_v,
    input logic [N_PINS-1:0] latch_v,
    input logic [N_PINS-1:0] sync_v
  );
    return (dir_v & latch_v) | (~dir_v & sync_v);
  endfunction

  gpio_addr_dec #(.N_PINS(N_PINS), .MASK_LSB(MASK_LSB)) u_dec (
    .sel  (bus_sel),
    .wr   (bus_wr),
    .addr (bus_addr),
    .dec  (dec),
    .mask (acc_mask)
  );

  gpio_sync #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pad_in),
    .dout  (pad_sync)
  );

  gpio_regs #(.N_PINS(N_PINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec     (dec),
    .mask    (acc_mask),
    .wdata   (bus_wdata),
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .alt_q   (alt_q)
  );

  gpio_padmux #(.N_PINS(N_PINS)) u_mux (
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .alt_q   (alt_q),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .alt_in  (alt_in)
  );

  assign pin_view = pin_value(dir_q, latch_q, pad_sync);

  always_comb begin
    bus_rdata = '0;
    if (dec.data_rd)     bus_rdata = pin_view & acc_mask;
    else if (dec.dir_rd) bus_rdata = dir_q;
    else if (dec.alt_rd) bus_rdata = alt_q;
  end

  AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) dec.data_rd |-> ((bus_rdata & ~acc_mask) == '0)) else $error("read leaked a masked-off bit"); // R4
  AST_PAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (dec.data_wr && !dec.dir_wr && !dec.alt_wr) |=> ((pad_out & dir_q & ~alt_q) == ((($past(bus_wdata) & $past(acc_mask)) | ($past(latch_q) & ~$past(acc_mask))) & dir_q & ~alt_q))) else $error("pad does not follow written data"); // R6
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !bus_sel |-> (bus_rdata == '0)) else $error("read data without a read"); // R9

endmodule

// File: tb/sim_gpio_masked_port.sv
module sim_gpio_masked_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [7:0]  pad_in = '0, pad_out, pad_oe;
  logic [7:0]  alt_out = '0, alt_oe = '0, alt_in;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_latch = '0, m_dir = '0, m_alt = '0;

  localparam logic [11:0] A_DIR = 12'h400;
  localparam logic [11:0] A_ALT = 12'h404;

  always #4 clk = ~clk; // 125 MHz

  gpio_masked_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
  );

  function automatic logic [11:0] data_addr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  function automatic logic [7:0] exp_pad_out();
    return (m_alt & alt_out) | (~m_alt & m_dir & m_latch);
  endfunction

  function automatic logic [7:0] exp_pad_oe();
    return (m_alt & alt_oe) | (~m_alt & m_dir);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // drive on a negedge, returns on the next negedge (one edge later)
  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  // combinational read at the current time, between edges
  task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0; bus_addr = '0;
  endtask

  task automatic model_data_write(input logic [7:0] m, input logic [7:0] d);
    m_latch = (d & m) | (m_latch & ~m);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    @(negedge clk);
    check("R1 pad_oe after reset", pad_oe, 8'h00);
    check("R1 pad_out after reset", pad_out, 8'h00);
    bus_read(A_DIR, r); check("R1 dir after reset", r, 8'h00);
    bus_read(A_ALT, r); check("R1 alt after reset", r, 8'h00);
    check("R9 idle rdata", bus_rdata, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] r;
    bus_write(A_DIR, 8'h0F); m_dir = 8'h0F;
    check("R2 pad_oe follows dir", pad_oe, 8'h0F);
    bus_read(A_DIR, r); check("R9 dir readback", r, 8'h0F);
  endtask

  task automatic t_masked_write();
    // R6: before the accepting edge, pad must not have moved
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = data_addr(8'h05); bus_wdata = 8'hFF;
    #1 check("R6 no change before edge", pad_out, exp_pad_out());
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    model_data_write(8'h05, 8'hFF);
    check("R6 pad after edge", pad_out, exp_pad_out());
    check("R3 masked write 05", pad_out, 8'h05);
    bus_write(data_addr(8'h0C), 8'h08); model_data_write(8'h0C, 8'h08);
    check("R3 masked write 0C keeps others", pad_out, 8'h09);
    bus_write(data_addr(8'h00), 8'hFF);
    check("R3 zero mask changes nothing", pad_out, 8'h09);
    bus_write(data_addr(8'hFF), 8'h06); model_data_write(8'hFF, 8'h06);
    check("R3 full mask", pad_out, exp_pad_out());
  endtask

  task automatic t_input_store();
    logic [7:0] r;
    bus_write(data_addr(8'hF0), 8'hA0); model_data_write(8'hF0, 8'hA0);
    check("R7 input write does not drive oe", pad_oe, 8'h0F);
    check("R7 input write does not drive out", pad_out, exp_pad_out());
    bus_write(A_DIR, 8'hFF); m_dir = 8'hFF;
    check("R7 stored value driven after dir", pad_out, 8'hA6);
    pad_in = 8'h5A;
    @(negedge clk); @(negedge clk); @(negedge clk);
    bus_read(data_addr(8'hFF), r);
    check("R5 output pin reads latch", r, 8'hA6);
  endtask

  task automatic t_read_input();
    logic [7:0] r;
    bus_write(A_DIR, 8'h00); m_dir = 8'h00;
    @(negedge clk);
    pad_in = 8'h3C;
    @(negedge clk); @(negedge clk);
    bus_read(data_addr(8'hFF), r); check("R5 input after sync", r, 8'h3C);
    bus_read(data_addr(8'h0F), r); check("R4 masked read 0F", r, 8'h0C);
    bus_read(data_addr(8'h81), r); check("R4 masked read 81", r, 8'h00);
    pad_in = 8'hC3;
    @(negedge clk);
    bus_read(data_addr(8'hFF), r); check("R5 one edge still old", r, 8'h3C);
    @(negedge clk);
    bus_read(data_addr(8'hFF), r); check("R5 two edges new", r, 8'hC3);
    bus_write(A_DIR, 8'h0F); m_dir = 8'h0F;
    bus_read(data_addr(8'hFF), r);
    check("R5 mixed pins", r, (m_latch & 8'h0F) | (8'hC3 & 8'hF0));
  endtask

  task automatic t_alternate();
    logic [7:0] r;
    alt_out = 8'h80; alt_oe = 8'h01; pad_in = 8'hFF;
    bus_write(A_ALT, 8'h81); m_alt = 8'h81;
    #1;
    check("R8 pad_out with alt", pad_out, exp_pad_out());
    check("R8 pad_oe with alt", pad_oe, exp_pad_oe());
    check("R8 alt_in gated", alt_in, 8'h81);
    alt_out = 8'h7F; alt_oe = 8'hFE; #1;
    check("R8 alt_out tracked", pad_out, exp_pad_out());
    check("R8 alt_oe tracked", pad_oe, exp_pad_oe());
    bus_read(A_ALT, r); check("R9 alt readback", r, 8'h81);
  endtask

  task automatic t_ignored();
    logic [7:0] r;
    bus_write(12'h408, 8'hFF);
    bus_read(A_DIR, r); check("R9 bad ctrl offset keeps dir", r, m_dir);
    bus_read(A_ALT, r); check("R9 bad ctrl offset keeps alt", r, m_alt);
    bus_read(12'h408, r); check("R9 bad ctrl offset reads 0", r, 8'h00);
    bus_write(12'h800 | data_addr(8'hFF), 8'hFF);
    bus_write(data_addr(8'hFF) | 12'h001, 8'hFF);
    check("R9 upper region and misaligned ignored", pad_out, exp_pad_out());
    bus_read(12'hC00, r); check("R9 upper region reads 0", r, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_direction();
    t_masked_write();
    t_input_store();
    t_read_input();
    t_alternate();
    t_ignored();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule